// File: doc/BRIEF.md
# Constant-Modulus Fold Reducer (mod 179)

This unit takes a 32-bit unsigned operand and returns its remainder modulo 179. It uses no divider. The method relies on 256 being congruent to 77 modulo 179. The bits above the low byte are repeatedly multiplied by 77 and folded back into an accumulator. A second loop pushes any carry out of the low byte back into the fold. One conditional subtraction of 179 at the end brings the value into range.

The block works sequentially and performs one fold or carry step per clock. A requester drives the operand and pulses `start` while the unit is idle. It then waits for the one-cycle `done` pulse and reads `result`. The result stays valid until the next accepted start. The modulus, fold width and accumulator width are parameters. The multiplier is derived from the modulus and the fold width.

Top module: `mod179_fold`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0 and `result` is 0.
- R2: A `start` sampled high while the unit is idle is accepted. `busy` is 1 in the following cycle and stays 1 until the computation completes.
- R3: For every 32-bit operand, the `result` presented with `done` equals the operand modulo 179.
- R4: The delivered `result` is always below 179. Operands whose folded value lands in 179..255 are reduced by exactly one subtraction of 179; for example 179 gives 0, 255 gives 76 and 358 gives 0.
- R5: `done` is high for exactly one cycle per accepted start, and `busy` is 0 in that cycle and in the cycle after it.
- R6: `result` keeps its value after `done` until another start is accepted, whatever the operand input does meanwhile.
- R7: A `start` pulse or operand change while `busy` is 1 is ignored. The running computation finishes with the result of the originally captured operand, and no further `done` follows.
- R8: From the clock edge that accepts `start`, `done` is high no more than 48 cycles later for any 32-bit operand.
- R9: The internal accumulator never wraps during a fold step, including for the operand 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse; honoured only while idle |
| operand | input | 32 | Unsigned value to reduce, captured at the accepting edge |
| busy | output | 1 | High while a reduction is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Operand modulo 179, held until the next accepted start |

## Verification
The number of cycles depends on the operand, because the fold loop repeats until the high part reaches zero. For that reason the bench does not wait a fixed delay. It drives `start` on a falling edge and expects `busy` one cycle later. It then counts falling edges until `done` appears and compares that count against the 48-cycle ceiling. The result is compared in the `done` cycle, the cycle after it is checked for a low `done`, and the held value is compared again several cycles later.

// File: rtl/mod179_pkg.sv
package mod179_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FOLD,
        ST_CARRY,
        ST_TRIM,
        ST_DONE
    } red_state_e;

    function automatic int fold_mult(input int fold_w, input int modulus);
        return (1 << fold_w) - modulus;
    endfunction

endpackage

// File: rtl/mod179_fold_step.sv
module mod179_fold_step #(
    parameter int ACC_W  = 16,
    parameter int QUO_W  = 24,
    parameter int FOLD_W = 8,
    parameter int MULT   = 77
) (
    input  logic [ACC_W-1:0] acc_in,
    input  logic [QUO_W-1:0] quo_in,
    output logic [ACC_W-1:0] acc_out,
    output logic [QUO_W-1:0] quo_out
);
    localparam int PROD_W = QUO_W + FOLD_W;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod    = PROD_W'(quo_in) * PROD_W'(MULT);
        acc_out = acc_in + ACC_W'(prod[FOLD_W-1:0]);
        quo_out = prod[PROD_W-1:FOLD_W];
    end
endmodule

// File: rtl/mod179_carry_split.sv
module mod179_carry_split #(
    parameter int ACC_W  = 16,
    parameter int QUO_W  = 24,
    parameter int FOLD_W = 8
) (
    input  logic [ACC_W-1:0] acc_in,
    output logic [ACC_W-1:0] acc_low,
    output logic [QUO_W-1:0] quo_high
);
    always_comb begin
        acc_low  = {{(ACC_W-FOLD_W){1'b0}}, acc_in[FOLD_W-1:0]};
        quo_high = QUO_W'(acc_in[ACC_W-1:FOLD_W]);
    end
endmodule

// File: rtl/mod179_trim.sv
module mod179_trim #(
    parameter int ACC_W   = 16,
    parameter int FOLD_W  = 8,
    parameter int MODULUS = 179
) (
    input  logic [ACC_W-1:0]  acc_in,
    output logic [FOLD_W-1:0] res_out
);
    always_comb begin
        if (acc_in >= ACC_W'(MODULUS))
            res_out = FOLD_W'(acc_in - ACC_W'(MODULUS));
        else
            res_out = FOLD_W'(acc_in);
    end
endmodule

// File: rtl/mod179_fold.sv
module mod179_fold
    import mod179_pkg::*;
#(
    parameter int OPER_W  = 32,
    parameter int FOLD_W  = 8,
    parameter int MODULUS = 179,
    parameter int ACC_W   = 16,
    parameter int MAX_LAT = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OPER_W-1:0] operand,
    output logic              busy,
    output logic              done,
    output logic [FOLD_W-1:0] result
);
    localparam int QUO_W = OPER_W - FOLD_W;
    localparam int MULT  = fold_mult(FOLD_W, MODULUS);
    localparam int LAT_W = $clog2(MAX_LAT + 2) + 1;

    red_state_e       state;
    logic [ACC_W-1:0] acc;
    logic [QUO_W-1:0] quo;

    logic [ACC_W-1:0]  acc_step, acc_low;
    logic [QUO_W-1:0]  quo_step, quo_high;
    logic [FOLD_W-1:0] res_trim;

    mod179_fold_step #(.ACC_W(ACC_W), .QUO_W(QUO_W), .FOLD_W(FOLD_W), .MULT(MULT)) u_step (
        .acc_in (acc),
        .quo_in (quo),
        .acc_out(acc_step),
        .quo_out(quo_step)
    );

    mod179_carry_split #(.ACC_W(ACC_W), .QUO_W(QUO_W), .FOLD_W(FOLD_W)) u_split (
        .acc_in  (acc),
        .acc_low (acc_low),
        .quo_high(quo_high)
    );

    mod179_trim #(.ACC_W(ACC_W), .FOLD_W(FOLD_W), .MODULUS(MODULUS)) u_trim (
        .acc_in (acc),
        .res_out(res_trim)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            acc    <= '0;
            quo    <= '0;
            result <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        acc   <= ACC_W'(operand[FOLD_W-1:0]);
                        quo   <= operand[OPER_W-1:FOLD_W];
                        state <= ST_FOLD;
                    end
                end
                ST_FOLD: begin
                    acc   <= acc_step;
                    quo   <= quo_step;
                    state <= (quo_step == '0) ? ST_CARRY : ST_FOLD;
                end
                ST_CARRY: begin
                    acc   <= acc_low;
                    quo   <= quo_high;
                    state <= (quo_high != '0) ? ST_FOLD : ST_TRIM;
                end
                ST_TRIM: begin
                    result <= res_trim;
                    state  <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state == ST_FOLD) || (state == ST_CARRY) || (state == ST_TRIM);
    assign done = (state == ST_DONE);

    // latency counter used only by the checks below
    logic [LAT_W-1:0] lat_cnt;
    always_ff @(posedge clk) begin
        if (rst || state == ST_IDLE)
            lat_cnt <= '0;
        else if (lat_cnt != '1)
            lat_cnt <= lat_cnt + 1'b1;
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> busy);

    // R4
    result_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (result < FOLD_W'(MODULUS)));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start) |=> $stable(result));

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_cnt <= LAT_W'(MAX_LAT)));

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FOLD) |-> (acc_step >= acc));
endmodule

// File: tb/mod179_fold_test.sv
module mod179_fold_test;
    localparam int CLK_PERIOD = 10;
    localparam int LAT_LIMIT  = 48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic        busy, done;
    logic [7:0]  result;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    mod179_fold uut (
        .clk(clk), .rst(rst), .start(start), .operand(operand),
        .busy(busy), .done(done), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] ref_mod(input logic [31:0] x);
        return 8'(x % 32'd179);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    // start one reduction; optionally disturb it with a start while busy (R7)
    task automatic run_one(input logic [31:0] x, input bit disturb);
        int cyc;
        int extra_done;
        logic [7:0] exp;
        exp = ref_mod(x);
        @(negedge clk);
        operand = x;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        operand = $urandom;
        check(busy == 1'b1, "R2 busy after start", 32'(busy), 1);
        cyc = 1;
        if (disturb) begin
            @(negedge clk);
            cyc++;
            operand = x ^ 32'h00A5_5A00;
            start = 1'b1;
            @(negedge clk);
            cyc++;
            start = 1'b0;
        end
        while (!done && cyc <= 200) begin
            @(negedge clk);
            cyc++;
        end
        check(done == 1'b1, "R5 done seen", 32'(done), 1);
        check(result == exp, "R3 result", 32'(result), 32'(exp));
        check(result < 8'd179, "R4 range", 32'(result), 178);
        check(cyc <= LAT_LIMIT, "R8 latency", 32'(cyc), LAT_LIMIT);
        @(negedge clk);
        check(!done && !busy, "R5 single pulse", 32'({busy, done}), 0);
        operand = ~x;
        extra_done = 0;
        for (int i = 0; i < (disturb ? 50 : 3); i++) begin
            @(negedge clk);
            if (done) extra_done++;
        end
        check(result == exp, "R6 hold", 32'(result), 32'(exp));
        if (disturb)
            check(extra_done == 0, "R7 no second run", 32'(extra_done), 0);
    endtask

    initial begin
        logic [31:0] dir_ops [0:6];
        void'($urandom(32'd179_2024));
        dir_ops[0] = 32'd0;
        dir_ops[1] = 32'd178;
        dir_ops[2] = 32'd179;
        dir_ops[3] = 32'd255;
        dir_ops[4] = 32'd256;
        dir_ops[5] = 32'd358;
        dir_ops[6] = 32'hFFFF_FFFF;  // R9 widest fold chain

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(!busy && !done, "R1 reset flags", 32'({busy, done}), 0);
        check(result == 8'd0, "R1 reset result", 32'(result), 0);

        // start ignored after reset? no: idle start is accepted (R2) in run_one
        for (int i = 0; i < 7; i++) run_one(dir_ops[i], 1'b0);

        // R7 disturbance on a large and a small operand
        run_one(32'hDEAD_BEEF, 1'b1);
        run_one(32'd300, 1'b1);

        for (int i = 0; i < 40; i++) run_one($urandom, 1'b0);
        for (int i = 0; i < 10; i++) run_one($urandom | 32'hFF00_0000, 1'b0);

        finish_run();
    end
endmodule